// File: doc/BRIEF.md
# Clock Monitor Reference Divider

This block turns two slow clocks, an external oscillator clock and an internal base clock, into a pair of reference strobes that a clock monitor uses to check each clock against the other. Both clocks are sampled in one fast system clock domain. Each one passes through its own two-flop synchronizer and a rising-edge detector, then through a fixed divide-by-four stage. One of the two paths also goes through a single long divider, which makes its reference far slower than the other clock. The slow-external configuration bit chooses which path gets the long divider.

The long divider is shared with a second task. While the external clock has not yet been declared stable, it acts as a settling timer for the external oscillator. It counts raw external edges and raises the external-stable flag once the chosen timeout has fully elapsed. After that, it goes back to dividing reference pulses. When the clock monitor reports the external clock as lost, the stable flag drops and the divider returns to timer mode. A full timeout is then needed again before the flag can return.

Top module: `clkmon_refdiv`

## Requirements
- R1: While the synchronous active-low reset is asserted, `ext_stable`, `ext_ref` and `int_ref` are 0 on the next clock. All counters are cleared.
- R2: The fixed path output is bit 1 of a two-bit count of source rising edges. It is 1 after 2 edges and 0 again after 4. With `slow_ext`=1 this output appears on `ext_ref` (external source). With `slow_ext`=0 it appears on `int_ref` (base source).
- R3: While `gen_en` is 0, the long divider is held at zero and `ext_stable` stays 0, however many external edges arrive.
- R4: With `xtal_en`=0, `ext_stable` rises after the 16th external rising edge counted since the timer was cleared, and not after the 15th.
- R5: With `xtal_en`=1, `ext_stable` rises after the 4096th external rising edge, and not after the 4095th.
- R6: While `ext_stable` is 0, base clock edges do not advance the settling timer.
- R7: Once stable, the long path output is the selected source divided by 4·4096. It starts at 0 and rises after 8192 source rising edges. With `slow_ext`=1 this output appears on `int_ref` (base source). With `slow_ext`=0 it appears on `ext_ref` (external source).
- R8: A cycle with `ext_lost`=1 clears `ext_stable` and the long divider. A new full timeout is then needed before `ext_stable` sets again.
- R9: While `ext_stable` is 0, the long path output (`int_ref` if `slow_ext`=1, else `ext_ref`) is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; both source clocks are sampled on it |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_clk | input | 1 | External oscillator clock, asynchronous |
| base_clk | input | 1 | Internal base clock, asynchronous |
| gen_en | input | 1 | External generator enable; low holds the long divider cleared |
| slow_ext | input | 1 | 1: long divider on the base path; 0: long divider on the external path |
| xtal_en | input | 1 | Settling timeout select: 0 gives 16 edges, 1 gives 4096 edges |
| ext_lost | input | 1 | External clock judged inactive by the clock monitor |
| ext_ref | output | 1 | External-derived reference |
| int_ref | output | 1 | Base-derived reference |
| ext_stable | output | 1 | External clock has completed its settling timeout |

## Verification
The hardest state to reach is a reference toggle on the long path. It needs the settling timeout to finish first, and then 8192 further source edges with the divide-by-four phase aligned. The bench gets there by counting every edge it drives from reset, so the fixed-stage phase is known at the moment the flag sets. It then checks the output just before and just after the exact toggle edge. The timer boundaries are checked the same way, one edge short and exactly on the count. The loss case is checked by pulsing `ext_lost` after a completed timeout and repeating the whole timeout.

// File: rtl/clkmon_refdiv.sv
module clkmon_refdiv #(
  parameter int LONG_LOG2  = 12,
  parameter int SHORT_LOG2 = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_clk,
  input  logic base_clk,
  input  logic gen_en,
  input  logic slow_ext,
  input  logic xtal_en,
  input  logic ext_lost,
  output logic ext_ref,
  output logic int_ref,
  output logic ext_stable
);

  localparam int LW = LONG_LOG2;

  logic [2:0]    ext_sy, base_sy;
  logic          ext_pls, base_pls;
  logic [1:0]    ext_q4, base_q4;
  logic [LW-1:0] lcnt, lcnt_inc;
  logic          stable_q;
  logic          tap_now, tap_next, stab_fall, ref_step, long_out;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ext_sy  <= '0;
      base_sy <= '0;
    end else begin
      ext_sy  <= {ext_sy[1:0], ext_clk};
      base_sy <= {base_sy[1:0], base_clk};
    end
  end

  assign ext_pls  = ext_sy[1] & ~ext_sy[2];
  assign base_pls = base_sy[1] & ~base_sy[2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ext_q4  <= '0;
      base_q4 <= '0;
    end else begin
      if (ext_pls)  ext_q4  <= ext_q4 + 2'd1;
      if (base_pls) base_q4 <= base_q4 + 2'd1;
    end
  end

  assign lcnt_inc  = lcnt + 1'b1;
  assign tap_now   = xtal_en ? lcnt[LW-1]     : lcnt[SHORT_LOG2-1];
  assign tap_next  = xtal_en ? lcnt_inc[LW-1] : lcnt_inc[SHORT_LOG2-1];
  assign stab_fall = ext_pls & tap_now & ~tap_next;
  assign ref_step  = slow_ext ? (base_pls & (base_q4 == 2'd3))
                              : (ext_pls & (ext_q4 == 2'd3));

  always_ff @(posedge clk) begin
    if (!rst_n || !gen_en || ext_lost) begin
      lcnt     <= '0;
      stable_q <= 1'b0;
    end else if (!stable_q) begin
      if (stab_fall) begin
        lcnt     <= '0;
        stable_q <= 1'b1;
      end else if (ext_pls) begin
        lcnt <= lcnt_inc;
      end
    end else if (ref_step) begin
      lcnt <= lcnt_inc;
    end
  end

  assign long_out   = stable_q & lcnt[LW-1];
  assign ext_ref    = slow_ext ? ext_q4[1] : long_out;
  assign int_ref    = slow_ext ? long_out  : base_q4[1];
  assign ext_stable = stable_q;

endmodule

module clkmon_refdiv_chk (
  input logic clk,
  input logic rst_n,
  input logic gen_en,
  input logic slow_ext,
  input logic ext_lost,
  input logic ext_ref,
  input logic int_ref,
  input logic ext_stable
);

  AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> (!ext_stable && !ext_ref && !int_ref)); // R1

  AST_GEN_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) !gen_en |=> !ext_stable); // R3

  AST_RISE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_stable) |-> ($past(gen_en) && !$past(ext_lost))); // R4

  AST_LOST_DROPS_STABLE: assert property (@(posedge clk) disable iff (!rst_n) ext_lost |=> !ext_stable); // R8

  AST_LONG_REF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_stable |-> (slow_ext ? !int_ref : !ext_ref)); // R9

endmodule

bind clkmon_refdiv clkmon_refdiv_chk u_chk (
  .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .slow_ext(slow_ext), .ext_lost(ext_lost),
  .ext_ref(ext_ref), .int_ref(int_ref), .ext_stable(ext_stable)
);

// File: tb/clkmon_refdiv_bench.sv
module clkmon_refdiv_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_clk = 1'b0, base_clk = 1'b0;
  logic gen_en = 1'b0, slow_ext = 1'b0, xtal_en = 1'b0, ext_lost = 1'b0;
  logic ext_ref, int_ref, ext_stable;
  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  clkmon_refdiv u_clkmon_refdiv (
    .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .base_clk(base_clk),
    .gen_en(gen_en), .slow_ext(slow_ext), .xtal_en(xtal_en), .ext_lost(ext_lost),
    .ext_ref(ext_ref), .int_ref(int_ref), .ext_stable(ext_stable)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; ext_clk = 1'b0; base_clk = 1'b0; ext_lost = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic ext_edges(input int n);
    for (int i = 0; i < n; i++) begin
      ext_clk = 1'b1; repeat (3) @(negedge clk);
      ext_clk = 1'b0; repeat (3) @(negedge clk);
    end
  endtask

  task automatic base_edges(input int n);
    for (int i = 0; i < n; i++) begin
      base_clk = 1'b1; repeat (3) @(negedge clk);
      base_clk = 1'b0; repeat (3) @(negedge clk);
    end
  endtask

  task automatic t_reset();
    gen_en = 1'b1; slow_ext = 1'b1; xtal_en = 1'b0;
    do_reset();
    check("R1 ext_stable", ext_stable, 1'b0);
    check("R1 ext_ref", ext_ref, 1'b0);
    check("R1 int_ref", int_ref, 1'b0);
  endtask

  task automatic t_fixed();
    gen_en = 1'b0; slow_ext = 1'b1;
    do_reset();
    ext_edges(2);
    check("R2 ext_ref after 2 ext edges", ext_ref, 1'b1);
    ext_edges(2);
    check("R2 ext_ref after 4 ext edges", ext_ref, 1'b0);
    slow_ext = 1'b0;
    base_edges(2);
    check("R2 int_ref after 2 base edges", int_ref, 1'b1);
    base_edges(2);
    check("R2 int_ref after 4 base edges", int_ref, 1'b0);
  endtask

  task automatic t_gen_off();
    gen_en = 1'b0; xtal_en = 1'b0;
    do_reset();
    ext_edges(40);
    check("R3 stable with gen_en low", ext_stable, 1'b0);
    gen_en = 1'b1;
    ext_edges(15);
    check("R3 timer was held at zero", ext_stable, 1'b0);
    ext_edges(1);
    check("R3 full timeout after enable", ext_stable, 1'b1);
  endtask

  task automatic t_stab16();
    gen_en = 1'b1; xtal_en = 1'b0; slow_ext = 1'b0;
    do_reset();
    ext_edges(15);
    check("R4 not stable after 15", ext_stable, 1'b0);
    check("R9 ext_ref low while unstable", ext_ref, 1'b0);
    base_edges(50);
    check("R6 base edges ignored by timer", ext_stable, 1'b0);
    ext_edges(1);
    check("R4 stable after 16", ext_stable, 1'b1);
  endtask

  task automatic t_stab4096();
    gen_en = 1'b1; xtal_en = 1'b1; slow_ext = 1'b1;
    do_reset();
    ext_edges(4095);
    check("R5 not stable after 4095", ext_stable, 1'b0);
    check("R9 int_ref low while unstable", int_ref, 1'b0);
    ext_edges(1);
    check("R5 stable after 4096", ext_stable, 1'b1);
  endtask

  task automatic t_ref_ext();
    gen_en = 1'b1; xtal_en = 1'b0; slow_ext = 1'b0;
    do_reset();
    ext_edges(16);
    check("R7 stable before ext ref", ext_stable, 1'b1);
    check("R7 ext_ref starts low", ext_ref, 1'b0);
    ext_edges(8191);
    check("R7 ext_ref low after 8191", ext_ref, 1'b0);
    ext_edges(1);
    check("R7 ext_ref high after 8192", ext_ref, 1'b1);
  endtask

  task automatic t_ref_int();
    gen_en = 1'b1; xtal_en = 1'b0; slow_ext = 1'b1;
    do_reset();
    ext_edges(16);
    check("R7 stable before int ref", ext_stable, 1'b1);
    base_edges(8191);
    check("R7 int_ref low after 8191", int_ref, 1'b0);
    base_edges(1);
    check("R7 int_ref high after 8192", int_ref, 1'b1);
    check("R2 ext_ref fixed path after 16 edges", ext_ref, 1'b0);
  endtask

  task automatic t_lost();
    gen_en = 1'b1; xtal_en = 1'b0; slow_ext = 1'b0;
    do_reset();
    ext_edges(16);
    check("R8 stable before loss", ext_stable, 1'b1);
    ext_lost = 1'b1; @(negedge clk); ext_lost = 1'b0; @(negedge clk);
    check("R8 stable cleared by loss", ext_stable, 1'b0);
    ext_edges(15);
    check("R8 not stable after 15 post-loss", ext_stable, 1'b0);
    ext_edges(1);
    check("R8 stable after 16 post-loss", ext_stable, 1'b1);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 195000) begin
        checks++; errors++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    t_reset();
    t_fixed();
    t_gen_off();
    t_stab16();
    t_stab4096();
    t_ref_ext();
    t_ref_int();
    t_lost();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule